// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache With Four-Word Lines

This block is a direct-mapped cache placed between a processor data port and a simple memory port. The processor side uses 32-bit byte addresses and 32-bit words. The memory side moves one word per transfer. Each line holds four words. A lookup splits the address into a tag, a line index and a word-in-line field. It then compares the stored tag of the indexed line and checks the line's valid flag. A read hit returns the selected word in the same cycle, with no stall.

On any miss the processor is stalled. The controller invalidates the indexed line and then fetches the whole line from memory. It issues one word read at a time, from the first word of the line to the last. Once the line is full it marks the line valid, and the held request is served again as a hit. Stores are write-through. A store hit updates the cached word and, in the same cycle, posts a one-beat write to memory that gets no reply. A store miss fills the line first, then merges the single word and posts the memory write.

The processor must hold its request, address and write data stable while the stall output is high. The memory port has no ready signal. It takes every request on the cycle it is raised, and later returns one read word with a one-cycle valid strobe.

Top module: `dmc_top`

## Requirements
- R1: After reset every line is invalid. No memory request is made during reset, and the first access to any address misses (stall high in its first cycle).
- R2: Address bits 31..16 form the tag, bits 15..4 the line index and bits 3..2 the word within the line. Bits 1..0 are ignored, so addresses that differ only there return the same word.
- R3: A hit needs a set valid flag and a stored tag equal to the address tag. A read hit completes in its first cycle (stall low) with the addressed word on cpu_rdata and no memory request.
- R4: On a hit, bits 3..2 select word 0, 1, 2 or 3 of the line, each returning the value last written for that exact word address.
- R5: On a miss, stall is high from the first cycle until the cycle in which the access completes. Exactly four memory reads are issued, in order, at {tag, index, k, 2'b00} for k = 0, 1, 2, 3. Only one read is outstanding at a time, and each read after the first is issued only after the previous read's valid strobe.
- R6: A store hit completes in its first cycle. It updates the cached word and raises mem_req with mem_we high, mem_addr equal to the store address with bits 1..0 cleared, and mem_wdata equal to the store data.
- R7: A store miss first performs the four-read line fill of R5 with no memory write during it. It then completes as in R6, and later reads of the other three words of that line return memory contents.
- R8: While no request is pending and no fill is in progress, mem_req stays low and stall stays low.
- R9: An access whose index matches a valid line with a different tag misses and replaces the line. The old address then misses again and returns the value memory holds, including earlier written-through stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until stall is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when cpu_req is high, cpu_we low and cpu_stall low |
| cpu_stall | output | 1 | High while the current access cannot complete |
| mem_req | output | 1 | Memory transfer request, accepted in the cycle it is high |
| mem_we | output | 1 | 1 = posted word write, 0 = word read |
| mem_addr | output | 32 | Word-aligned byte address of the transfer |
| mem_wdata | output | 32 | Write data for a posted write |
| mem_rdata | input | 32 | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | One-cycle strobe returning the outstanding read word |

## Verification
The bench keeps its own model of which tag each index holds and what memory contains, and it checks every access cycle by cycle against that model under a memory whose read latency rotates between one and three cycles. It hits byte-offset aliases, all four words of a line, and a store followed by a load of the same word; a design that skipped the cache update on a store would return stale data there. It forces conflicts on a shared index and the top index 0xFFF. A design that kept the old line valid, or filled words out of order or from the wrong base, would show a wrong fill address or a hit where a miss is due. A store miss is checked for a complete fill before its single memory write, so a design that wrote only the word, or wrote memory mid-fill, would fail on a later load of a neighbouring word or on a write seen while stalled.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    // Controller phases: idle lookup, issuing a fill read, waiting for its data
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_AWAIT  = 2'd2
    } fill_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int INDEX_W = 12,
    parameter int TAG_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               lk_hit,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic               wr_valid
);
    localparam int DEPTH = 1 << INDEX_W;

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

    // R5
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_valid && lk_idx == wr_idx && lk_tag == wr_tag)
        |=> (!$stable(lk_idx) || !$stable(lk_tag) || lk_hit));

    // R9
    inval_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid && lk_idx == wr_idx)
        |=> (!$stable(lk_idx) || !lk_hit));

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int INDEX_W = 12,
    parameter int OFF_W   = 2,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_idx,
    input  logic [OFF_W-1:0]   rd_off,
    output logic [DATA_W-1:0]  rd_word,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0]   wr_off,
    input  logic [DATA_W-1:0]  wr_word
);
    localparam int WORDS = 1 << OFF_W;
    localparam int DEPTH = 1 << INDEX_W;

    logic [DATA_W-1:0] lane_rd [WORDS];

    // One storage lane per word of the line; the word field picks the lane
    for (genvar g = 0; g < WORDS; g++) begin : g_lane
        logic [DATA_W-1:0] lane_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_off == OFF_W'(g)) begin
                lane_q[wr_idx] <= wr_word;
            end
        end

        assign lane_rd[g] = lane_q[rd_idx];
    end

    assign rd_word = lane_rd[rd_off];

    // R4
    word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_idx == wr_idx && rd_off == wr_off)
        |=> (!$stable(rd_idx) || !$stable(rd_off) || rd_word == $past(wr_word)));

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic             lk_hit,
    input  logic             mem_rvalid,
    output logic             cpu_stall,
    output logic             mem_req,
    output logic             mem_we,
    output logic             fill_active,
    output logic [OFF_W-1:0] fill_off,
    output logic             tag_wr_en,
    output logic             tag_wr_valid,
    output logic             data_wr_en
);
    localparam logic [OFF_W-1:0] LAST_OFF = '1;

    typedef struct packed {
        fill_state_e      state;
        logic [OFF_W-1:0] cnt;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        cpu_stall    = 1'b0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        tag_wr_en    = 1'b0;
        tag_wr_valid = 1'b0;
        data_wr_en   = 1'b0;
        unique case (r_q.state)
            ST_LOOKUP: begin
                if (cpu_req) begin
                    if (lk_hit) begin
                        if (cpu_we) begin
                            data_wr_en = 1'b1;
                            mem_req    = 1'b1;
                            mem_we     = 1'b1;
                        end
                    end else begin
                        cpu_stall = 1'b1;
                        tag_wr_en = 1'b1;   // drop the old line before refilling
                        r_d.state = ST_ISSUE;
                        r_d.cnt   = '0;
                    end
                end
            end
            ST_ISSUE: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                r_d.state = ST_AWAIT;
            end
            ST_AWAIT: begin
                cpu_stall = 1'b1;
                if (mem_rvalid) begin
                    data_wr_en = 1'b1;
                    if (r_q.cnt == LAST_OFF) begin
                        tag_wr_en    = 1'b1;
                        tag_wr_valid = 1'b1;
                        r_d.state    = ST_LOOKUP;
                    end else begin
                        r_d.cnt   = r_q.cnt + OFF_W'(1);
                        r_d.state = ST_ISSUE;
                    end
                end
            end
            default: r_d.state = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_LOOKUP, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign fill_active = (r_q.state != ST_LOOKUP);
    assign fill_off    = r_q.cnt;

    // R5
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !(mem_req && !mem_we));

    // R7
    no_write_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> !(mem_req && mem_we));

    // R3
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !cpu_stall) |-> !mem_req);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req && !fill_active) |-> (!mem_req && !cpu_stall));

endmodule

// File: rtl/dmc_top.sv
module dmc_top #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 12,
    parameter int OFF_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);
    localparam int BYTE_W  = $clog2(DATA_W / 8);
    localparam int IDX_LSB = BYTE_W + OFF_W;
    localparam int TAG_W   = ADDR_W - INDEX_W - OFF_W - BYTE_W;
    localparam logic [ADDR_W-1:0] BYTE_MASK = ADDR_W'((1 << BYTE_W) - 1);

    logic [ADDR_W-1:0]  word_addr;
    logic [TAG_W-1:0]   addr_tag;
    logic [INDEX_W-1:0] addr_idx;
    logic [OFF_W-1:0]   addr_off;
    logic [ADDR_W-1:0]  fill_addr;

    logic             lk_hit;
    logic             fill_active;
    logic [OFF_W-1:0] fill_off;
    logic             tag_wr_en;
    logic             tag_wr_valid;
    logic             data_wr_en;

    // Byte offset is dropped here; only word-aligned addresses go further
    assign word_addr = cpu_addr & ~BYTE_MASK;
    assign addr_tag  = word_addr[ADDR_W-1 -: TAG_W];
    assign addr_idx  = word_addr[IDX_LSB +: INDEX_W];
    assign addr_off  = word_addr[BYTE_W +: OFF_W];
    assign fill_addr = {addr_tag, addr_idx, fill_off, {BYTE_W{1'b0}}};

    dmc_ctrl #(
        .OFF_W (OFF_W)
    ) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .lk_hit       (lk_hit),
        .mem_rvalid   (mem_rvalid),
        .cpu_stall    (cpu_stall),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .fill_active  (fill_active),
        .fill_off     (fill_off),
        .tag_wr_en    (tag_wr_en),
        .tag_wr_valid (tag_wr_valid),
        .data_wr_en   (data_wr_en)
    );

    dmc_tag_store #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W)
    ) i_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (addr_idx),
        .lk_tag   (addr_tag),
        .lk_hit   (lk_hit),
        .wr_en    (tag_wr_en),
        .wr_idx   (addr_idx),
        .wr_tag   (addr_tag),
        .wr_valid (tag_wr_valid)
    );

    dmc_data_store #(
        .INDEX_W (INDEX_W),
        .OFF_W   (OFF_W),
        .DATA_W  (DATA_W)
    ) i_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (addr_idx),
        .rd_off  (addr_off),
        .rd_word (cpu_rdata),
        .wr_en   (data_wr_en),
        .wr_idx  (addr_idx),
        .wr_off  (fill_active ? fill_off : addr_off),
        .wr_word (fill_active ? mem_rdata : cpu_wdata)
    );

    assign mem_addr  = fill_active ? fill_addr : word_addr;
    assign mem_wdata = cpu_wdata;

    // R6
    store_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !cpu_stall)
        |-> (mem_req && mem_we && mem_wdata == cpu_wdata
             && mem_addr[BYTE_W-1:0] == '0
             && mem_addr[ADDR_W-1:BYTE_W] == cpu_addr[ADDR_W-1:BYTE_W]));

endmodule

// File: tb/test_dmc_top.sv
module test_dmc_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_rvalid;

    always #4 clk = ~clk;   // 125 MHz

    dmc_top i_dmc_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .cpu_stall  (cpu_stall),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference state: tag held per index, and memory as the CPU sees it
    logic [15:0] mtag    [int unsigned];
    logic [31:0] ref_mem [int unsigned];
    logic [31:0] dev_mem [int unsigned];

    function automatic logic [31:0] dflt(input logic [31:0] w);
        return w * 32'h2545F491 + 32'h13579BDF;
    endfunction

    function automatic logic [31:0] ref_rd(input logic [31:0] w);
        if (ref_mem.exists(w)) return ref_mem[w];
        return dflt(w);
    endfunction

    function automatic bit model_hit(input logic [31:0] a);
        return mtag.exists(int'(a[15:4])) && mtag[int'(a[15:4])] == a[31:16];
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Memory device: samples the port late in each cycle, answers reads
    // after a latency that rotates over 0..2 extra cycles
    initial begin
        bit          busy = 0;
        int          wcnt = 0;
        int          lat  = 0;
        logic [31:0] raddr = '0;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            #2;
            mem_rvalid = 1'b0;
            if (busy) begin
                if (wcnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = dev_mem.exists(raddr >> 2) ? dev_mem[raddr >> 2]
                                                           : dflt(raddr >> 2);
                    busy = 0;
                end else begin
                    wcnt--;
                end
            end
            if (rst_n && mem_req) begin
                if (mem_we) begin
                    dev_mem[mem_addr >> 2] = mem_wdata;
                end else begin
                    busy  = 1;
                    raddr = mem_addr;
                    wcnt  = lat;
                    lat   = (lat + 1) % 3;
                end
            end
        end
    end

    task automatic do_access(input bit we, input logic [31:0] addr,
                             input logic [31:0] wd, input string lbl);
        bit          exp_hit;
        int          nrd = 0;
        int          cyc = 0;
        bit          fin = 0;
        logic [31:0] exp_a;
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = addr;
        cpu_wdata = wd;
        exp_hit   = model_hit(addr);
        while (!fin) begin
            #1;
            if (cyc == 0) begin
                check(cpu_stall == !exp_hit, lbl, 32'(cpu_stall), 32'(!exp_hit));
            end
            if (mem_req && !mem_we) begin
                exp_a = {addr[31:4], nrd[1:0], 2'b00};
                check(mem_addr == exp_a, lbl, mem_addr, exp_a);
                nrd++;
            end
            if (cpu_stall && mem_req && mem_we) begin
                check(1'b0, "R7", mem_addr, 32'hFFFF_FFFF);
            end
            if (!cpu_stall) begin
                fin = 1;
                check(nrd == (exp_hit ? 0 : 4), lbl, 32'(nrd), exp_hit ? 32'd0 : 32'd4);
                if (we) begin
                    exp_a = {addr[31:2], 2'b00};
                    check(mem_req && mem_we && mem_addr == exp_a && mem_wdata == wd,
                          lbl, mem_addr, exp_a);
                end else begin
                    check(cpu_rdata == ref_rd(addr >> 2), lbl, cpu_rdata, ref_rd(addr >> 2));
                    check(!mem_req, lbl, 32'(mem_req), 32'd0);
                end
            end else begin
                cyc++;
                if (cyc > 200) begin
                    check(1'b0, lbl, 32'(cyc), 32'd200);
                    fin = 1;
                end else begin
                    @(negedge clk);
                end
            end
        end
        mtag[int'(addr[15:4])] = addr[31:16];
        if (we) ref_mem[addr >> 2] = wd;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
        for (int i = 0; i < n; i++) begin
            #1;
            // R8: no memory traffic and no stall without a request
            check(!mem_req && !cpu_stall, "R8", {30'd0, mem_req, cpu_stall}, 32'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] seed;
        logic [31:0] a;
        logic [15:0] tags [3];
        logic [11:0] idxs [4];
        bit          w;
        tags = '{16'h0001, 16'h0005, 16'h7777};
        idxs = '{12'h002, 12'h014, 12'hFFF, 12'h3A0};
        seed = 32'h1badcafe;

        rst_n     = 1'b0;
        cpu_req   = 1'b0;
        cpu_we    = 1'b0;
        cpu_addr  = '0;
        cpu_wdata = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            // R1: quiet during reset
            check(!mem_req && !cpu_stall, "R1", {30'd0, mem_req, cpu_stall}, 32'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 cold miss, R3 hit, R4 word select, R2 byte offset ignored
        do_access(0, 32'h0001_0020, 0, "R1");
        do_access(0, 32'h0001_0020, 0, "R3");
        do_access(0, 32'h0001_0024, 0, "R4");
        do_access(0, 32'h0001_0028, 0, "R4");
        do_access(0, 32'h0001_002C, 0, "R4");
        do_access(0, 32'h0001_002D, 0, "R2");
        do_access(0, 32'h0001_0022, 0, "R2");
        // R6 store hit then load of the same word
        do_access(1, 32'h0001_0028, 32'hDEAD_BEEF, "R6");
        do_access(0, 32'h0001_002A, 0, "R6");
        // R7 store miss: fill first, then merge
        do_access(1, 32'h0002_0144, 32'h0000_1234, "R7");
        do_access(0, 32'h0002_0144, 0, "R7");
        do_access(0, 32'h0002_0140, 0, "R7");
        do_access(0, 32'h0002_014C, 0, "R7");
        // R9 conflict on index 2
        do_access(0, 32'h0005_0020, 0, "R9");
        do_access(0, 32'h0001_0028, 0, "R9");
        do_access(0, 32'h0005_0024, 0, "R9");
        idle(5);
        // R5 top index
        do_access(0, 32'hABCD_FFFC, 0, "R5");
        do_access(0, 32'hABCD_FFF0, 0, "R3");

        for (int i = 0; i < 48; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            a = {tags[seed[17:16] % 3], idxs[seed[21:20]], seed[25:24], seed[27:26]};
            w = seed[30];
            if (w) do_access(1, a, seed ^ 32'h5A5A_0F0F, model_hit(a) ? "R6" : "R7");
            else   do_access(0, a, 0, model_hit(a) ? "R3" : "R5");
        end
        idle(3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R5 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule